// File: doc/BRIEF.md
# Quadrature Phase Skew Stage

This stage sits in a transmit datapath ahead of a pair of DACs that feed an analog quadrature modulator. When the modulator's I and Q paths are not exactly 90 degrees apart, an unwanted sideband appears. This stage pre-distorts the digital signal to cancel that error. It mixes a scaled copy of the I sample into the Q sample, which turns the angle between the two channels. A correction word of 10 bits sets the size and the direction of the turn.

The correction word is read as a two's-complement number. The most negative code moves Q about 14 degrees away from I, for an angle of about 104 degrees. The most positive code moves Q about 14 degrees toward I, for an angle of about 76 degrees. The step is close to 0.027 degrees per code. The coefficient applied to I is the word divided by 2048, so its magnitude is about 0.25 at the extremes, which is roughly tan 14 degrees. The I sample is not changed. It is delayed by the same two register stages as the Q computation, so the two channels stay aligned in time. The stage does no exact trigonometric correction and no amplitude re-normalisation.

Top module: `iq_phase_skew`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `i_out` and `q_out` read zero after that edge.
- R2: `i_out` equals the `i_in` value sampled two rising edges earlier, with no change to the value.
- R3: `q_out` equals `q_in - floor(phase_word * i_in / 2048)`, with every operand taken as two's complement and with the inputs sampled two rising edges earlier.
- R4: When `phase_word` is 0, `q_out` equals `q_in` delayed by two rising edges.
- R5: A Q result above 32767 comes out as 32767 (0x7FFF), and a result below -32768 comes out as -32768 (0x8000).
- R6: The extreme codes give the largest mix. For `i_in` = 32767, code 10'b1000000000 (-512) adds 8192 to Q, and code 10'b0111111111 (+511) subtracts 8175 from Q.
- R7: A positive word with a positive `i_in` never makes `q_out` larger than the delayed `q_in`. A negative word with a positive `i_in` never makes it smaller.
- R8: The floor rounds toward minus infinity. For example, word +1 with `i_in` = -1 adds 1 to Q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| i_in | input | 16 | I sample, two's complement |
| q_in | input | 16 | Q sample, two's complement |
| phase_word | input | 10 | Signed angle correction word |
| i_out | output | 16 | I sample delayed by two cycles |
| q_out | output | 16 | Corrected and saturated Q sample |

## Verification
The assertions check four things on every cycle once the pipeline holds samples taken after reset:
- the two-cycle alignment of I;
- that a zero word passes Q through unchanged;
- that the direction of the Q shift follows the signs of the word and of I;
- that reset clears both outputs.

Only the bench scenarios can show the following:
- the exact arithmetic at the two extreme codes and at intermediate codes;
- the floor rounding for negative products;
- clamping at both ends of the 16-bit range;
- correct results when a new sample arrives on every cycle.

// File: rtl/iq_skew_pkg.sv
package iq_skew_pkg;
  parameter int unsigned SAMPLE_W = 16;
  parameter int unsigned WORD_W   = 10;
  parameter int unsigned FRAC_SH  = 11;

  function automatic int unsigned wider(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/iq_skew_delay.sv
module iq_skew_delay #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] tap [DEPTH];

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_tap
      always_ff @(posedge clk) begin
        if (rst) begin
          tap[k] <= '0;
        end else if (k == 0) begin
          tap[k] <= din;
        end else begin
          tap[k] <= tap[(k == 0) ? 0 : k-1];
        end
      end
    end
  endgenerate

  assign dout = tap[DEPTH-1];
endmodule

// File: rtl/iq_skew_mult.sv
module iq_skew_mult #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 10,
  localparam int unsigned PW = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] i_s,
  input  logic signed [CW-1:0] w_s,
  output logic signed [PW-1:0] prod
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prod <= '0;
    end else begin
      prod <= w_s * i_s;
    end
  end
endmodule

// File: rtl/iq_skew_sat.sv
module iq_skew_sat #(
  parameter int unsigned DW    = 16,
  parameter int unsigned PW    = 26,
  parameter int unsigned SHIFT = 11,
  localparam int unsigned XW   = iq_skew_pkg::wider(DW, PW) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [PW-1:0] prod,
  input  logic signed [DW-1:0] q_d,
  output logic signed [DW-1:0] q_o
);
  localparam logic signed [XW-1:0] SAT_HI = $signed({{(XW-DW+1){1'b0}}, {(DW-1){1'b1}}});
  localparam logic signed [XW-1:0] SAT_LO = ~SAT_HI;

  logic signed [PW-1:0] scaled;
  logic signed [XW-1:0] q_ext;
  logic signed [XW-1:0] s_ext;
  logic signed [XW-1:0] diff;
  logic signed [DW-1:0] clamped;

  always_comb begin
    scaled = prod >>> SHIFT;
    q_ext  = {{(XW-DW){q_d[DW-1]}}, q_d};
    s_ext  = {{(XW-PW){scaled[PW-1]}}, scaled};
    diff   = q_ext - s_ext;
    if (diff > SAT_HI) begin
      clamped = SAT_HI[DW-1:0];
    end else if (diff < SAT_LO) begin
      clamped = SAT_LO[DW-1:0];
    end else begin
      clamped = diff[DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else begin
      q_o <= clamped;
    end
  end
endmodule

// File: rtl/iq_phase_skew.sv
module iq_phase_skew #(
  parameter int unsigned DW    = iq_skew_pkg::SAMPLE_W,
  parameter int unsigned CW    = iq_skew_pkg::WORD_W,
  parameter int unsigned SHIFT = iq_skew_pkg::FRAC_SH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] i_in,
  input  logic signed [DW-1:0] q_in,
  input  logic signed [CW-1:0] phase_word,
  output logic signed [DW-1:0] i_out,
  output logic signed [DW-1:0] q_out
);
  localparam int unsigned PW      = DW + CW;
  localparam int unsigned LATENCY = 2;

  logic signed [PW-1:0] prod;
  logic signed [DW-1:0] q_align;

  iq_skew_mult #(.DW(DW), .CW(CW)) u_mult (
    .clk(clk), .rst(rst), .i_s(i_in), .w_s(phase_word), .prod(prod)
  );

  iq_skew_delay #(.W(DW), .DEPTH(LATENCY-1)) u_qdly (
    .clk(clk), .rst(rst), .din(q_in), .dout(q_align)
  );

  iq_skew_sat #(.DW(DW), .PW(PW), .SHIFT(SHIFT)) u_sat (
    .clk(clk), .rst(rst), .prod(prod), .q_d(q_align), .q_o(q_out)
  );

  iq_skew_delay #(.W(DW), .DEPTH(LATENCY)) u_idly (
    .clk(clk), .rst(rst), .din(i_in), .dout(i_out)
  );
endmodule

// File: rtl/iq_phase_skew_chk.sv
module iq_phase_skew_chk #(
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = 10,
  parameter int unsigned SHIFT = 11
) (
  input logic                 clk,
  input logic                 rst,
  input logic signed [DW-1:0] i_in,
  input logic signed [DW-1:0] q_in,
  input logic signed [CW-1:0] phase_word,
  input logic signed [DW-1:0] i_out,
  input logic signed [DW-1:0] q_out
);
  logic [1:0] run_cnt = 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= 2'd0;
    end else if (run_cnt != 2'd2) begin
      run_cnt <= run_cnt + 2'd1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (i_out == '0 && q_out == '0));

  assert_i_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == 2'd2) |-> (i_out == $past(i_in, 2)));

  assert_zero_word_R4: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == 2'd2 && $past(phase_word, 2) == '0) |-> (q_out == $past(q_in, 2)));

  assert_pos_pull_R7: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == 2'd2 && $past(phase_word, 2) > 0 && $past(i_in, 2) > 0)
      |-> (q_out <= $past(q_in, 2)));

  assert_neg_pull_R7: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == 2'd2 && $past(phase_word, 2) < 0 && $past(i_in, 2) > 0)
      |-> (q_out >= $past(q_in, 2)));
endmodule

bind iq_phase_skew iq_phase_skew_chk #(.DW(DW), .CW(CW), .SHIFT(SHIFT)) u_chk (.*);

// File: tb/sim_iq_phase_skew.sv
`timescale 1ns/1ps
module sim_iq_phase_skew;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [15:0] i_in = '0;
  logic signed [15:0] q_in = '0;
  logic signed [9:0]  phase_word = '0;
  logic signed [15:0] i_out;
  logic signed [15:0] q_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  iq_phase_skew u0 (
    .clk(clk), .rst(rst), .i_in(i_in), .q_in(q_in),
    .phase_word(phase_word), .i_out(i_out), .q_out(q_out)
  );

  function automatic int model_q(input int i, input int q, input int w);
    int p, s, d;
    p = w * i;
    s = p >>> 11;
    d = q - s;
    if (d > 32767) d = 32767;
    if (d < -32768) d = -32768;
    return d;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int i, input int q, input int w);
    @(negedge clk);
    i_in = 16'(i); q_in = 16'(q); phase_word = 10'(w);
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk);
    i_in = 16'sd1234; q_in = -16'sd999; phase_word = 10'sd100;
    @(posedge clk); @(posedge clk); #1;
    check("R1 i_out in reset", i_out, 0);
    check("R1 q_out in reset", q_out, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_zero_word();
    apply(20000, -12345, 0);
    check("R4 q passthrough", q_out, -12345);
    check("R2 i passthrough", i_out, 20000);
  endtask

  task automatic t_endpoints();
    apply(32767, 100, -512);
    check("R6 most negative code", q_out, 100 + 8192);
    apply(32767, 100, 511);
    check("R6 most positive code", q_out, 100 - 8175);
    check("R2 i at endpoint", i_out, 32767);
  endtask

  task automatic t_mid_codes();
    apply(-3000, 500, 37);
    check("R3 mid code neg i", q_out, model_q(-3000, 500, 37));
    apply(15000, -7000, -200);
    check("R3 mid code neg w", q_out, model_q(15000, -7000, -200));
    apply(12000, 4000, 300);
    check("R7 positive pull", q_out, model_q(12000, 4000, 300));
  endtask

  task automatic t_floor();
    apply(-1, 10, 1);
    check("R8 floor of -1/2048", q_out, 11);
  endtask

  task automatic t_saturate();
    apply(32767, 30000, -512);
    check("R5 clamp high", q_out, 32767);
    apply(32767, -30000, 511);
    check("R5 clamp low", q_out, -32768);
  endtask

  task automatic t_stream();
    int si [10];
    int sq [10];
    int sw [10];
    for (int k = 0; k < 10; k++) begin
      si[k] = (k * 7919) % 65536 - 32768;
      sq[k] = (k * 4513) % 60000 - 30000;
      sw[k] = (k * 97) % 1024 - 512;
    end
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check("R2 stream i", i_out, si[k-2]);
        check("R3 stream q", q_out, model_q(si[k-2], sq[k-2], sw[k-2]));
      end
      if (k < 10) begin
        i_in = 16'(si[k]); q_in = 16'(sq[k]); phase_word = 10'(sw[k]);
      end
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_zero_word();
    t_endpoints();
    t_mid_codes();
    t_floor();
    t_saturate();
    t_stream();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule